// File: doc/BRIEF.md
# Serial 1101 Sequence Detector

This block watches a serial bit stream that presents one new bit per clock. It raises a flag whenever the four most recent bits, oldest first, read 1, 1, 0, 1. Matches may overlap. The trailing `1` of one match can serve as the leading `1` of the next, so the stream `1101101` contains two matches.

Two detectors read the same input in parallel.

- **Early detector.** Its flag is combinational. It rises in the same cycle that the final `1` sits on the input.
- **Late detector.** Its flag comes straight from a state register. It rises in the cycle after that final `1` was sampled.

A design that needs the result before the next edge uses the early flag. A design that needs a glitch-free registered flag uses the late one.

Top module: `seq1101_detector`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, both detectors return to their idle state. In the cycle after such an edge, both flags read 0, and no bits seen before the reset can contribute to a later match.
- R2: `match_early` is 1 exactly when two conditions hold together: the three bits sampled at the three most recent edges since reset were 1, 1, 0 (oldest first), and `ser_in` currently holds 1.
- R3: `match_late` is 1 exactly in the cycle after an edge that sampled the final `1` of a `1101` sequence. It stays high for that one cycle only.
- R4: Matches overlap. The input `1101101` gives two matches three cycles apart, because after a match a `1` leaves the detector as if `11` had just been seen.
- R5: A run of ones of any length followed by `0`, `1` gives a match. Extra leading ones do not reset the progress.
- R6: `match_late` always equals the value `match_early` had one cycle earlier, counted from the first edge after reset.
- R7: `match_early` is never 1 while `ser_in` is 0. Near misses such as `1100`, `1001` and `1111` give no match on either flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| ser_in | input | 1 | Serial data bit, one per clock |
| match_early | output | 1 | Combinational flag: the current bit completes 1101 |
| match_late | output | 1 | Registered flag: the previous bit completed 1101 |

## Verification
The bench aims at three corner cases.

- **Overlapping matches (`1101101`).** A detector that returns to idle after a hit would miss the second match.
- **Long runs of ones before `01`.** A detector that drops back on a third `1` would never flag them.
- **Reset in the middle of a partial `110`.** If stale history leaked across the reset, a single `1` after it would raise a false match.

Constrained random streams biased toward ones cover the near misses. In every cycle, both flags are compared against a four-bit shift-register model. This exposes a late flag that lasts two cycles or arrives at the wrong edge, and an early flag that ignores the live input.

// File: rtl/seq1101_pkg.sv
// Shared state types for the 1101 sequence detectors.
// The late detector's codes are fixed: its flag is taken from bit 2,
// which only the hit state sets.
package seq1101_pkg;

    typedef enum logic [2:0] {
        LT_IDLE   = 3'b000,
        LT_ONE    = 3'b001,
        LT_ONEONE = 3'b010,
        LT_OOZ    = 3'b011,
        LT_HIT    = 3'b100
    } late_state_t;

    typedef enum logic [1:0] {
        EA_IDLE   = 2'b00,
        EA_ONE    = 2'b01,
        EA_ONEONE = 2'b10,
        EA_OOZ    = 2'b11
    } early_state_t;

endpackage

// File: rtl/seq1101_late.sv
// Registered-output (Moore) detector for the serial pattern 1101.
// Five states; the flag is state bit 2, high only in the hit state.
// Assumes: one bit per clock, synchronous active-low reset.
module seq1101_late
    import seq1101_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ser_in,
    output logic match_late
);

    late_state_t state_q;
    late_state_t state_d;

    // Next-state selection from the progress so far and the new bit.
    always_comb begin
        state_d = LT_IDLE;
        unique case (state_q)
            LT_IDLE:   state_d = ser_in ? LT_ONE    : LT_IDLE;
            LT_ONE:    state_d = ser_in ? LT_ONEONE : LT_IDLE;
            LT_ONEONE: state_d = ser_in ? LT_ONEONE : LT_OOZ;
            LT_OOZ:    state_d = ser_in ? LT_HIT    : LT_IDLE;
            LT_HIT:    state_d = ser_in ? LT_ONEONE : LT_IDLE;
            default:   state_d = LT_IDLE;
        endcase
    end

    // State register with synchronous reset to idle.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LT_IDLE;
        else        state_q <= state_d;
    end

    // Flag is the top state bit; no logic after the register.
    assign match_late = state_q[2];

    // R3: a hit is never held for two cycles (the next match needs three more bits).
    a_r3_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        match_late |=> !match_late);

    // R4: after a hit, a 1 leaves the machine with "11" already seen.
    a_r4_overlap_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (match_late && ser_in) |=> (state_q == LT_ONEONE));

    // R5: runs of ones do not lose progress.
    a_r5_ones_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LT_ONEONE && ser_in) |=> (state_q == LT_ONEONE));

endmodule

// File: rtl/seq1101_early.sv
// Combinational-output (Mealy) detector for the serial pattern 1101.
// Four states; the flag rises while "110" is stored and the live bit is 1.
// Assumes: one bit per clock, synchronous active-low reset.
module seq1101_early
    import seq1101_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ser_in,
    output logic match_early
);

    early_state_t state_q;
    early_state_t state_d;

    // Next state and flag from the stored progress and the live bit.
    always_comb begin
        state_d     = EA_IDLE;
        match_early = 1'b0;
        unique case (state_q)
            EA_IDLE:   state_d = ser_in ? EA_ONE    : EA_IDLE;
            EA_ONE:    state_d = ser_in ? EA_ONEONE : EA_IDLE;
            EA_ONEONE: state_d = ser_in ? EA_ONEONE : EA_OOZ;
            EA_OOZ: begin
                state_d     = ser_in ? EA_ONE : EA_IDLE;
                match_early = ser_in;
            end
            default:   state_d = EA_IDLE;
        endcase
    end

    // State register with synchronous reset to idle.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= EA_IDLE;
        else        state_q <= state_d;
    end

    // R7: the flag needs the live bit to be 1.
    a_r7_needs_one: assert property (@(posedge clk) disable iff (!rst_n)
        match_early |-> ser_in);

    // R4: after a hit the machine holds one 1, ready for "1101" to overlap.
    a_r4_after_hit: assert property (@(posedge clk) disable iff (!rst_n)
        match_early |=> (state_q == EA_ONE));

endmodule

// File: rtl/seq1101_detector.sv
// Top of the 1101 serial detector: an early (Mealy) and a late (Moore)
// detector read the same serial input side by side.
// Assumes: one bit per clock, synchronous active-low reset.
module seq1101_detector (
    input  logic clk,
    input  logic rst_n,
    input  logic ser_in,
    output logic match_early,
    output logic match_late
);

    seq1101_early u_early (
        .clk         (clk),
        .rst_n       (rst_n),
        .ser_in      (ser_in),
        .match_early (match_early)
    );

    seq1101_late u_late (
        .clk        (clk),
        .rst_n      (rst_n),
        .ser_in     (ser_in),
        .match_late (match_late)
    );

    // R6: the late flag is the early flag one cycle on.
    a_r6_late_follows: assert property (@(posedge clk) disable iff (!rst_n)
        match_early |=> match_late);
    a_r6_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !match_early |=> !match_late);

endmodule

// File: tb/sim_seq1101_detector.sv
`timescale 1ns/1ps
module sim_seq1101_detector;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_in = 1'b0;
    logic match_early;
    logic match_late;

    int checks = 0;
    int failures = 0;
    logic [2:0] hist = 3'b000;   // last three sampled bits, newest in bit 0
    int valid = 0;               // bits sampled since reset
    logic exp_late = 1'b0;
    logic done = 1'b0;

    always #2.5 clk = ~clk;

    seq1101_detector u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .ser_in      (ser_in),
        .match_early (match_early),
        .match_late  (match_late)
    );

    function automatic logic ref_match(logic [2:0] h, int n, logic b);
        return (n >= 3) && ({h, b} == 4'b1101);
    endfunction

    task automatic check(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s at %0t: actual=%b expected=%b", req, $time, act, exp);
        end
    endtask

    // Drive one bit after the falling edge, check both flags, then let the edge sample it.
    task automatic push(logic b, string tag);
        logic e;
        @(negedge clk);
        ser_in = b;
        #0.5;
        e = ref_match(hist, valid, b);
        check({tag, " R2 early"}, match_early, e);
        check({tag, " R3/R6 late"}, match_late, exp_late);
        exp_late = e;
        hist = {hist[1:0], b};
        valid++;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        ser_in = 1'b1;
        @(negedge clk);
        @(negedge clk);
        #0.5;
        check("R1 early in reset", match_early, 1'b0);
        check("R1 late in reset", match_late, 1'b0);
        rst_n = 1'b1;
        hist = 3'b000;
        valid = 0;
        exp_late = 1'b0;
    endtask

    task automatic push_seq(logic [15:0] bits, int len, string tag);
        for (int i = len - 1; i >= 0; i--) push(bits[i], tag);
    endtask

    initial begin
        void'($urandom(32'd1101));
        do_reset();
        // R4: overlapping pair, then zeros to drain
        push_seq(16'b1101101, 7, "R4 overlap");
        push_seq(16'b000, 3, "R4 drain");
        // R5: long run of ones before 01
        push_seq(16'b11111101, 8, "R5 ones");
        push_seq(16'b00, 2, "R5 drain");
        // R7: near misses
        push_seq(16'b1100100111110000, 16, "R7 near");
        // R1: reset in the middle of 110, then a single 1
        push_seq(16'b110, 3, "R1 pre");
        do_reset();
        push(1'b1, "R1 post");
        push(1'b0, "R1 post");
        push(1'b0, "R1 post");
        // Random streams biased toward ones
        for (int i = 0; i < 400; i++) push(($urandom % 4) != 0, "R6 random");
        push(1'b0, "R6 tail");
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                failures++;
                checks++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule